// File: doc/BRIEF.md
# Memory-Mapped BCD Calendar Clock

A calendar and time-of-day counter that answers on a byte-wide, SRAM-style host bus. Its eight register bytes occupy the eight highest addresses of the bus. Together they hold the century, year, month, date, weekday, hour, minute and second. Each value is stored as two packed BCD digits. A single-cycle one-hertz enable advances the time once per second. The counter handles every carry through the full calendar, including month lengths and leap years.

Several register bytes also carry control and status bits. A stop bit halts timekeeping. A read-freeze bit gives the host a stable snapshot while the counter keeps running. A write-hold bit stages a new time, which the block loads when the bit is cleared. A test-enable bit brings out a one-hertz square wave. A status bit always reads as good. The bus is synchronous to `clk`. Writes take effect on the clock edge. Read data is combinational from the address and strobes. The data bus is split into `din`, `dout` and a drive flag `dout_en`. Addresses below the register window are not answered.

Top module: `bcd_calendar_clock`

## Requirements
- R1: After reset the registers read, by address offset from the top of the window, 7 year 0x00, 6 month 0x01, 5 date 0x01, 4 weekday 0x81, 3 hour 0x00, 2 minute 0x00, 1 second 0x00, 0 century 0x20.
- R2: Each accepted tick advances the seconds. Seconds roll from 59 to 00 and carry into minutes. Minutes roll from 59 to 00 and carry into hours. Hours roll from 23 to 00 and carry into the date and the weekday.
- R3: The date rolls to 01 and the month advances after day 28 or 29 of month 02, after day 30 of months 04, 06, 09 and 11, and after day 31 of the other months. February has 29 days when the BCD year is a multiple of four, 00 included. Month 12 rolls to 01 and carries into the year.
- R4: The weekday (offset 4, bits 2:0) counts 1 to 7, and 7 is followed by 1.
- R5: Year 99 rolls to 00 and increments the century (offset 0, bits 5:0). Century 39 rolls to 00.
- R6: While bit 7 of the seconds byte is 1, ticks do not change any time field. Writing the bit back to 0 resumes counting.
- R7: While bit 6 of the century byte is 1, reads return the time captured at the edge that set the bit, while the counter keeps advancing. After the bit clears, reads show the advanced time.
- R8: While bit 7 of the century byte is 1, ticks are ignored and writes go only to the staged copy, which reads return. Writing the bit to 0 loads the staged values, the century written in that same cycle included, as the new time.
- R9: On a write each byte keeps only its defined bits: year 7:0, month 4:0, date 5:0, weekday 2:0 plus test enable 6, hour 5:0, minute 6:0, seconds 6:0 plus stop 7, century 5:0 plus bits 7:6. Bit 7 of the weekday byte always reads 1. The other undefined bits read 0.
- R10: `dout_en` is 1 only when `cs_n`=0, `oe_n`=0, `we_n`=1 and the address is in the window. Otherwise `dout` is 0x00.
- R11: A write happens when `cs_n`=0 and `we_n`=0, whatever the value of `oe_n`, and `dout_en` is 0 throughout the write.
- R12: When the test enable is 1 and the stop bit is 0, `ft_out` is 1 for the HALF_CYC clock cycles that follow each tick and 0 afterwards. Otherwise it stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick_1hz | input | 1 | One-cycle pulse once per second |
| cs_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| addr | input | ADDR_W | Byte address |
| din | input | 8 | Write data |
| dout | output | 8 | Read data, 0 when not driven |
| dout_en | output | 1 | Drive enable for the read data |
| ft_out | output | 1 | Test square wave |

## Verification
The assertions assume that the host writes only legal BCD values inside each field's range, and that a bus write never falls in the same cycle as a tick. The carry properties leave such cycles out. The stimulus keeps to both conditions: every value it loads is a legal calendar time, and ticks and writes are issued in separate clock cycles. The read-freeze and write-hold properties also assume that a frozen copy changes only through a host write, so the checks on them ignore cycles with a write.

// File: rtl/cal_pkg.sv
package cal_pkg;

  localparam logic [2:0] SEL_CEN  = 3'd0;
  localparam logic [2:0] SEL_SEC  = 3'd1;
  localparam logic [2:0] SEL_MIN  = 3'd2;
  localparam logic [2:0] SEL_HOUR = 3'd3;
  localparam logic [2:0] SEL_DAY  = 3'd4;
  localparam logic [2:0] SEL_DATE = 3'd5;
  localparam logic [2:0] SEL_MON  = 3'd6;
  localparam logic [2:0] SEL_YEAR = 3'd7;

  typedef struct packed {
    logic [7:0] cen;
    logic [7:0] yr;
    logic [7:0] mon;
    logic [7:0] date;
    logic [7:0] day;
    logic [7:0] hr;
    logic [7:0] mn;
    logic [7:0] sec;
  } cal_time_t;

  localparam cal_time_t RESET_TIME = cal_time_t'(64'h2000_0101_0100_0000);

  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
    return {v[7:4], v[3:0] + 4'd1};
  endfunction

  function automatic logic [6:0] bcd_to_bin(input logic [7:0] v);
    return 7'(v[7:4]) * 7'd10 + 7'(v[3:0]);
  endfunction

  function automatic logic leap_year(input logic [7:0] yr);
    logic [6:0] b;
    b = bcd_to_bin(yr);
    return b[1:0] == 2'b00;
  endfunction

  function automatic logic [7:0] month_len(input logic [7:0] mon, input logic [7:0] yr);
    case (mon)
      8'h02:                      return leap_year(yr) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction

  function automatic logic [7:0] field_mask(input logic [2:0] sel);
    case (sel)
      SEL_YEAR: return 8'hFF;
      SEL_MON:  return 8'h1F;
      SEL_DATE: return 8'h3F;
      SEL_DAY:  return 8'h07;
      SEL_HOUR: return 8'h3F;
      SEL_MIN:  return 8'h7F;
      SEL_SEC:  return 8'h7F;
      default:  return 8'h3F;
    endcase
  endfunction

  function automatic logic [7:0] time_get(input cal_time_t t, input logic [2:0] sel);
    case (sel)
      SEL_CEN:  return t.cen;
      SEL_SEC:  return t.sec;
      SEL_MIN:  return t.mn;
      SEL_HOUR: return t.hr;
      SEL_DAY:  return t.day;
      SEL_DATE: return t.date;
      SEL_MON:  return t.mon;
      default:  return t.yr;
    endcase
  endfunction

  function automatic cal_time_t time_put(input cal_time_t t, input logic [2:0] sel,
                                         input logic [7:0] v);
    cal_time_t r;
    r = t;
    case (sel)
      SEL_CEN:  r.cen  = v;
      SEL_SEC:  r.sec  = v;
      SEL_MIN:  r.mn   = v;
      SEL_HOUR: r.hr   = v;
      SEL_DAY:  r.day  = v;
      SEL_DATE: r.date = v;
      SEL_MON:  r.mon  = v;
      default:  r.yr   = v;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/cal_bus_decode.sv
module cal_bus_decode #(
  parameter int ADDR_W = 19
) (
  input  logic              cs_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  output logic [2:0]        sel,
  output logic              rd_act,
  output logic              wr_act
);
  logic hit;

  assign hit    = &addr[ADDR_W-1:3];
  assign sel    = addr[2:0];
  assign rd_act = hit && !cs_n && !oe_n && we_n;
  assign wr_act = hit && !cs_n && !we_n;
endmodule

// File: rtl/cal_tick_chain.sv
module cal_tick_chain
  import cal_pkg::*;
(
  input  cal_time_t cur,
  output cal_time_t nxt,
  output logic      day_wrap,
  output logic      yr_wrap
);
  logic sec_wrap, min_wrap, hr_wrap, date_wrap, mon_wrap;

  always_comb begin
    sec_wrap  = cur.sec >= 8'h59;
    min_wrap  = sec_wrap && (cur.mn >= 8'h59);
    hr_wrap   = min_wrap && (cur.hr >= 8'h23);
    day_wrap  = hr_wrap && (cur.day >= 8'h07);
    date_wrap = hr_wrap && (cur.date >= month_len(cur.mon, cur.yr));
    mon_wrap  = date_wrap && (cur.mon >= 8'h12);
    yr_wrap   = mon_wrap && (cur.yr >= 8'h99);

    nxt     = cur;
    nxt.sec = sec_wrap ? 8'h00 : bcd_inc(cur.sec);
    if (sec_wrap)  nxt.mn   = min_wrap ? 8'h00 : bcd_inc(cur.mn);
    if (min_wrap)  nxt.hr   = hr_wrap ? 8'h00 : bcd_inc(cur.hr);
    if (hr_wrap)   nxt.day  = day_wrap ? 8'h01 : cur.day + 8'h01;
    if (hr_wrap)   nxt.date = date_wrap ? 8'h01 : bcd_inc(cur.date);
    if (date_wrap) nxt.mon  = mon_wrap ? 8'h01 : bcd_inc(cur.mon);
    if (mon_wrap)  nxt.yr   = yr_wrap ? 8'h00 : bcd_inc(cur.yr);
    if (yr_wrap)   nxt.cen  = (cur.cen >= 8'h39) ? 8'h00 : bcd_inc(cur.cen);
  end
endmodule

// File: rtl/cal_ft_gen.sv
module cal_ft_gen #(
  parameter int HALF_CYC = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic enable,
  output logic ft_out
);
  localparam int CW = $clog2(HALF_CYC + 1);
  localparam logic [CW-1:0] HALF = CW'(HALF_CYC);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt_q <= HALF;
    else if (tick)         cnt_q <= '0;
    else if (cnt_q < HALF) cnt_q <= cnt_q + 1'b1;
  end

  assign ft_out = enable && (cnt_q < HALF);
endmodule

// File: rtl/bcd_calendar_clock.sv
module bcd_calendar_clock
  import cal_pkg::*;
#(
  parameter int ADDR_W   = 19,
  parameter int HALF_CYC = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_1hz,
  input  logic              cs_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        din,
  output logic [7:0]        dout,
  output logic              dout_en,
  output logic              ft_out
);
  cal_time_t  live_q, snap_q, live_d, snap_d, stepped, after_tick, snap_wr, view;
  logic       stop_q, ft_q, wbit_q, rbit_q;
  logic [2:0] sel;
  logic       rd_act, wr_act, frozen, adv, w_fall, day_wrap, yr_wrap;
  logic [7:0] wdata, raw, rd_byte;

  cal_bus_decode #(.ADDR_W(ADDR_W)) u_dec (
    .cs_n(cs_n), .oe_n(oe_n), .we_n(we_n), .addr(addr),
    .sel(sel), .rd_act(rd_act), .wr_act(wr_act)
  );

  cal_tick_chain u_chain (
    .cur(live_q), .nxt(stepped), .day_wrap(day_wrap), .yr_wrap(yr_wrap)
  );

  cal_ft_gen #(.HALF_CYC(HALF_CYC)) u_ft (
    .clk(clk), .rst_n(rst_n), .tick(tick_1hz), .enable(ft_q && !stop_q), .ft_out(ft_out)
  );

  // Events brought out for the checker
  assign frozen = wbit_q || rbit_q;
  assign adv    = tick_1hz && !stop_q && !wbit_q;
  assign w_fall = wr_act && (sel == SEL_CEN) && wbit_q && !din[7];
  assign wdata  = din & field_mask(sel);

  always_comb begin
    after_tick = adv ? stepped : live_q;
    snap_wr    = time_put(snap_q, sel, wdata);
    if (w_fall)                 live_d = snap_wr;
    else if (wr_act && !wbit_q) live_d = time_put(after_tick, sel, wdata);
    else                        live_d = after_tick;
    if (!frozen)                snap_d = live_d;
    else if (wr_act && wbit_q)  snap_d = snap_wr;
    else                        snap_d = snap_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      live_q <= RESET_TIME;
      snap_q <= RESET_TIME;
      stop_q <= 1'b0;
      ft_q   <= 1'b0;
      wbit_q <= 1'b0;
      rbit_q <= 1'b0;
    end else begin
      live_q <= live_d;
      snap_q <= snap_d;
      if (wr_act) begin
        case (sel)
          SEL_SEC: stop_q <= din[7];
          SEL_DAY: ft_q   <= din[6];
          SEL_CEN: begin
            wbit_q <= din[7];
            rbit_q <= din[6];
          end
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    view = frozen ? snap_q : live_q;
    raw  = time_get(view, sel);
    case (sel)
      SEL_SEC: rd_byte = {stop_q, raw[6:0]};
      SEL_DAY: rd_byte = {1'b1, ft_q, 3'b000, raw[2:0]};
      SEL_CEN: rd_byte = {wbit_q, rbit_q, raw[5:0]};
      default: rd_byte = raw;
    endcase
  end

  assign dout_en = rd_act;
  assign dout    = rd_act ? rd_byte : 8'h00;
endmodule

// File: rtl/cal_clock_checker.sv
module cal_clock_checker
  import cal_pkg::*;
(
  input logic      clk,
  input logic      rst_n,
  input logic      cs_n,
  input logic      oe_n,
  input logic      we_n,
  input logic      dout_en,
  input logic      ft_out,
  input logic      stop_q,
  input logic      ft_q,
  input logic      wbit_q,
  input logic      rbit_q,
  input logic      host_wr,
  input logic      adv,
  input logic      day_wrap,
  input logic      yr_wrap,
  input cal_time_t live,
  input cal_time_t snap
);
  a_r2_bcd_legal: assert property (@(posedge clk) disable iff (!rst_n)
    (live.sec <= 8'h59) && (live.sec[3:0] <= 4'd9) &&
    (live.mn <= 8'h59) && (live.mn[3:0] <= 4'd9) &&
    (live.hr <= 8'h23) && (live.hr[3:0] <= 4'd9));

  a_r4_day_wraps_to_one: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && day_wrap && !host_wr) |=> (live.day == 8'h01));

  a_r5_century_carry: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && yr_wrap && !host_wr) |=> ((live.yr == 8'h00) && (live.cen != $past(live.cen))));

  a_r6_stop_freezes: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_q && !host_wr) |=> $stable(live));

  a_r7_snapshot_held: assert property (@(posedge clk) disable iff (!rst_n)
    (rbit_q && !host_wr) |=> $stable(snap));

  a_r8_hold_blocks_count: assert property (@(posedge clk) disable iff (!rst_n)
    (wbit_q && !host_wr) |=> $stable(live));

  a_r10_drive_needs_read: assert property (@(posedge clk) disable iff (!rst_n)
    dout_en |-> (!cs_n && !oe_n && we_n));

  a_r11_write_silences_bus: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && !we_n) |-> !dout_en);

  a_r12_ft_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!ft_q || stop_q) |-> !ft_out);
endmodule

bind bcd_calendar_clock cal_clock_checker u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .oe_n(oe_n), .we_n(we_n),
  .dout_en(dout_en), .ft_out(ft_out), .stop_q(stop_q), .ft_q(ft_q),
  .wbit_q(wbit_q), .rbit_q(rbit_q), .host_wr(wr_act), .adv(adv),
  .day_wrap(day_wrap), .yr_wrap(yr_wrap), .live(live_q), .snap(snap_q)
);

// File: tb/test_bcd_calendar_clock.sv
`timescale 1ns/1ps
module test_bcd_calendar_clock;
  localparam int AW   = 19;
  localparam int HALF = 8;
  localparam int NV   = 14;
  // each entry: {start time, time after one tick}, fields {cen,yr,mon,date,day,hr,min,sec}
  localparam logic [127:0] VEC [NV] = '{
    {64'h2024_0115_0310_2030, 64'h2024_0115_0310_2031},
    {64'h2024_0115_0310_2059, 64'h2024_0115_0310_2100},
    {64'h2024_0115_0310_5959, 64'h2024_0115_0311_0000},
    {64'h2024_0115_0723_5959, 64'h2024_0116_0100_0000},
    {64'h2023_0228_0223_5959, 64'h2023_0301_0300_0000},
    {64'h2024_0228_0223_5959, 64'h2024_0229_0300_0000},
    {64'h2024_0229_0323_5959, 64'h2024_0301_0400_0000},
    {64'h2024_0430_0123_5959, 64'h2024_0501_0200_0000},
    {64'h2024_1231_0523_5959, 64'h2025_0101_0600_0000},
    {64'h2099_1231_0623_5959, 64'h2100_0101_0700_0000},
    {64'h3999_1231_0723_5959, 64'h0000_0101_0100_0000},
    {64'h2024_0131_0123_5959, 64'h2024_0201_0200_0000},
    {64'h1909_0930_0123_5959, 64'h1909_1001_0200_0000},
    {64'h2000_0228_0123_5959, 64'h2000_0229_0200_0000}
  };

  logic          clk = 1'b0, rst_n = 1'b0, tick_1hz = 1'b0;
  logic          cs_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [7:0]    din = 8'h00, dout, rb;
  logic          dout_en, ft_out;
  int            checks = 0, errors = 0;
  bit            done = 1'b0;

  always #4 clk = ~clk;

  bcd_calendar_clock #(.ADDR_W(AW), .HALF_CYC(HALF)) i_bcd_calendar_clock (
    .clk(clk), .rst_n(rst_n), .tick_1hz(tick_1hz), .cs_n(cs_n), .oe_n(oe_n),
    .we_n(we_n), .addr(addr), .din(din), .dout(dout), .dout_en(dout_en), .ft_out(ft_out)
  );

  function automatic logic [AW-1:0] reg_addr(input logic [2:0] off);
    return {{(AW-3){1'b1}}, off};
  endfunction

  function automatic int slot(input logic [2:0] off);
    return (off == 3'd0) ? 56 : (int'(off) - 1) * 8;
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] off, input logic [7:0] val, input logic oe = 1'b1);
    @(negedge clk);
    cs_n = 1'b0; we_n = 1'b0; oe_n = oe; addr = reg_addr(off); din = val;
    #2;
    if (!oe) check("R11 drive off during write", {7'd0, dout_en}, 8'h00);
    @(negedge clk);
    cs_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
  endtask

  task automatic rd(input logic [2:0] off, output logic [7:0] v);
    @(negedge clk);
    cs_n = 1'b0; oe_n = 1'b0; we_n = 1'b1; addr = reg_addr(off);
    #2;
    v = dout;
    cs_n = 1'b1; oe_n = 1'b1;
  endtask

  task automatic pulse_tick();
    @(negedge clk);
    tick_1hz = 1'b1;
    @(negedge clk);
    tick_1hz = 1'b0;
  endtask

  task automatic expect_reg(input string req, input logic [2:0] off, input logic [7:0] exp);
    logic [7:0] v;
    rd(off, v);
    check(req, v, exp);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=hung expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset image
    expect_reg("R1 year",    3'd7, 8'h00);
    expect_reg("R1 month",   3'd6, 8'h01);
    expect_reg("R1 date",    3'd5, 8'h01);
    expect_reg("R1 weekday", 3'd4, 8'h81);
    expect_reg("R1 hour",    3'd3, 8'h00);
    expect_reg("R1 minute",  3'd2, 8'h00);
    expect_reg("R1 second",  3'd1, 8'h00);
    expect_reg("R1 century", 3'd0, 8'h20);
    check("R12 ft idle", {7'd0, ft_out}, 8'h00);

    // R10: drive conditions
    @(negedge clk);
    cs_n = 1'b0; oe_n = 1'b0; we_n = 1'b1; addr = '0; #2;
    check("R10 outside window en", {7'd0, dout_en}, 8'h00);
    check("R10 outside window data", dout, 8'h00);
    addr = reg_addr(3'd0); oe_n = 1'b1; #1;
    check("R10 oe high", {7'd0, dout_en}, 8'h00);
    oe_n = 1'b0; cs_n = 1'b1; #1;
    check("R10 cs high", {7'd0, dout_en}, 8'h00);
    cs_n = 1'b0; #1;
    check("R10 read drives", {7'd0, dout_en}, 8'h01);
    cs_n = 1'b1; oe_n = 1'b1;

    // R11: write with output enable asserted
    wr(3'd2, 8'h45, 1'b0);
    expect_reg("R11 write with oe low", 3'd2, 8'h45);

    // Table walk: R2..R5
    for (int i = 0; i < NV; i++) begin
      logic [63:0] st, ex;
      st = VEC[i][127:64];
      ex = VEC[i][63:0];
      wr(3'd0, 8'h80 | st[63:56]);
      for (int k = 7; k >= 1; k--) wr(3'(k), st[slot(3'(k)) +: 8]);
      wr(3'd0, st[63:56]);
      pulse_tick();
      for (int k = 0; k < 8; k++) begin
        logic [7:0] e;
        string req;
        e = ex[slot(3'(k)) +: 8];
        case (k)
          0, 7: req = "R5 year/century";
          4: begin req = "R4 weekday"; e = e | 8'h80; end
          5, 6: req = "R3 date/month";
          default: req = "R2 sec/min/hour";
        endcase
        expect_reg($sformatf("%s vec %0d", req, i), 3'(k), e);
      end
    end

    // R9: masking and status bit
    wr(3'd4, 8'hC7);
    expect_reg("R9 weekday with test enable", 3'd4, 8'hC7);
    wr(3'd4, 8'h07);
    expect_reg("R9 weekday status reads 1", 3'd4, 8'h87);
    wr(3'd3, 8'hD3);
    expect_reg("R9 hour mask", 3'd3, 8'h13);
    wr(3'd6, 8'hE5);
    expect_reg("R9 month mask", 3'd6, 8'h05);
    wr(3'd5, 8'hC7);
    expect_reg("R9 date mask", 3'd5, 8'h07);
    wr(3'd2, 8'h92);
    expect_reg("R9 minute mask", 3'd2, 8'h12);

    // R6: stop bit
    wr(3'd1, 8'h90);
    repeat (3) pulse_tick();
    expect_reg("R6 stopped seconds", 3'd1, 8'h90);
    expect_reg("R6 stopped minutes", 3'd2, 8'h12);
    wr(3'd1, 8'h10);
    pulse_tick();
    expect_reg("R6 resumed", 3'd1, 8'h11);

    // R12: test square wave
    wr(3'd4, 8'h47);
    @(negedge clk);
    tick_1hz = 1'b1;
    @(negedge clk);
    tick_1hz = 1'b0;
    check("R12 high after tick", {7'd0, ft_out}, 8'h01);
    repeat (HALF - 1) @(negedge clk);
    check("R12 high at end of half", {7'd0, ft_out}, 8'h01);
    @(negedge clk);
    check("R12 low after half", {7'd0, ft_out}, 8'h00);
    wr(3'd1, 8'h92);
    pulse_tick();
    check("R12 quiet while stopped", {7'd0, ft_out}, 8'h00);
    wr(3'd1, 8'h12);
    wr(3'd4, 8'h07);
    pulse_tick();
    check("R12 quiet when disabled", {7'd0, ft_out}, 8'h00);
    expect_reg("R6 count after restart", 3'd1, 8'h13);

    // R7: read freeze
    wr(3'd0, 8'h59);
    expect_reg("R7 snapshot seconds", 3'd1, 8'h13);
    pulse_tick();
    pulse_tick();
    expect_reg("R7 frozen seconds", 3'd1, 8'h13);
    expect_reg("R7 century flag", 3'd0, 8'h59);
    wr(3'd0, 8'h19);
    expect_reg("R7 counted underneath", 3'd1, 8'h15);

    // R8: write hold
    wr(3'd0, 8'h99);
    wr(3'd2, 8'h30);
    wr(3'd1, 8'h05);
    expect_reg("R8 staged seconds", 3'd1, 8'h05);
    expect_reg("R8 century flag", 3'd0, 8'h99);
    pulse_tick();
    pulse_tick();
    expect_reg("R8 held seconds", 3'd1, 8'h05);
    wr(3'd0, 8'h19);
    expect_reg("R8 loaded seconds", 3'd1, 8'h05);
    expect_reg("R8 loaded minutes", 3'd2, 8'h30);
    expect_reg("R8 loaded century", 3'd0, 8'h19);
    pulse_tick();
    expect_reg("R8 counting resumed", 3'd1, 8'h06);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule